// File: doc/BRIEF.md
# Demand Scrub Writeback Controller

This block sits between a memory controller's read-return path and a small pool of read data buffers. Every returning read fills one buffer and is forwarded to the requester on the following cycle, with the corrected data and the correctable and uncorrectable flags. If a read of real DRAM comes back with a correctable error, the block marks the receiving buffer dirty. It then schedules a writeback of that buffer. The corrected 8-byte word is stored back at its original, word-aligned address, and the downstream encoder attaches fresh ECC. This repairs the location before it can be read again.

Reads that decode to the MMIO window are never made dirty. Reads carrying an uncorrectable flag are never made dirty either, so bad data is never written back. A buffer that is still dirty, or whose writeback is in flight, can be released by its owner at any time. The release is remembered, and the buffer becomes free only once the memory side has acknowledged the writeback. A running count of completed scrub writebacks is kept for status.

Each buffer runs its own state machine with four states:

| State | Meaning |
|---|---|
| SLOT_FREE | unused |
| SLOT_CLEAN | holds data that needs no repair |
| SLOT_DIRTY | waiting for the writeback engine |
| SLOT_WRITING | writeback issued, waiting for the acknowledge |

The slot transitions are:

- fill: SLOT_FREE to SLOT_CLEAN, or SLOT_FREE to SLOT_DIRTY.
- release: SLOT_CLEAN to SLOT_FREE.
- grant: SLOT_DIRTY to SLOT_WRITING.
- done: SLOT_WRITING to SLOT_FREE if a release arrived earlier or arrives in the same cycle, otherwise to SLOT_CLEAN.

The writeback engine has two states, WB_IDLE and WB_BUSY. It moves WB_IDLE to WB_BUSY on a grant to the lowest-numbered dirty slot. It moves WB_BUSY back to WB_IDLE on the acknowledge.

Top module: `dsw_demand_scrub`

## Requirements
- R1: One cycle after a read return, req_valid is high and req_buf and req_data repeat the read's buffer index and data. req_ce equals rd_ce AND NOT rd_ue, and req_ue equals rd_ue. Without a read, req_valid is low in the next cycle.
- R2: A read with rd_ce=1 and rd_ue=0 to an address outside the MMIO window makes that buffer's buf_dirty bit 1 in the next cycle.
- R3: A read with rd_ce=0 leaves the buffer clean: buf_busy is 1 and buf_dirty is 0, and no writeback is issued for it.
- R4: A read with rd_ue=1 leaves the buffer clean and issues no writeback, whatever rd_ce is.
- R5: An address A is in the MMIO window when MMIO_BASE <= A < MMIO_LIMIT (defaults 0xC000_0000 and 0xE000_0000). A read to such an address never makes the buffer dirty, even with rd_ce=1.
- R6: When the engine is idle and at least one buffer is dirty, wb_valid rises one cycle later, and wb_buf names the lowest-numbered dirty buffer.
- R7: wb_addr is the buffer's read address with its low 3 bits cleared, because repair works on one 8-byte word. wb_data is the buffer's corrected read data.
- R8: While wb_valid is high and wb_ack is low, wb_valid, wb_buf, wb_addr and wb_data hold their values into the next cycle.
- R9: A release of a clean buffer clears its buf_busy bit in the next cycle. A release of a dirty or writing buffer takes effect only at the writeback acknowledge, so buf_busy clears in the cycle after wb_ack. A release of a free buffer has no effect.
- R10: scrub_cnt increases by exactly one, modulo 2^CNT_W, in the cycle after each wb_valid and wb_ack pair, and is unchanged otherwise.
- R11: After reset, every buffer is free and clean, wb_valid and req_valid are low, and scrub_cnt is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_valid | input | 1 | Read return strobe |
| rd_buf | input | IDX_W | Receiving buffer index |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | input | DATA_W | Corrected read data |
| rd_ce | input | 1 | Correctable error was corrected |
| rd_ue | input | 1 | Uncorrectable error |
| req_valid | output | 1 | Data to requester valid |
| req_buf | output | IDX_W | Buffer index to requester |
| req_data | output | DATA_W | Data to requester |
| req_ce | output | 1 | Correctable-error notification |
| req_ue | output | 1 | Uncorrectable-error notification |
| wb_valid | output | 1 | Writeback request |
| wb_buf | output | IDX_W | Buffer being written back |
| wb_addr | output | ADDR_W | Word-aligned writeback address |
| wb_data | output | DATA_W | Writeback data |
| wb_ack | input | 1 | Memory side accepted the writeback |
| rel_valid | input | 1 | Buffer release strobe |
| rel_buf | input | IDX_W | Buffer to release |
| buf_busy | output | NUM_BUF | Buffer is not free, one bit per buffer |
| buf_dirty | output | NUM_BUF | Buffer is dirty or its writeback is in flight |
| scrub_cnt | output | CNT_W | Completed scrub writebacks |

## Verification
The assertions assume that a read return only targets a buffer whose buf_busy bit is 0. They also assume that wb_ack is raised only while wb_valid is high. The bench keeps a cycle-accurate model of every buffer state, so it draws the read target only from buffers the model shows as free, and it raises the acknowledge only while the model expects a pending writeback. Addresses are drawn from both sides of each MMIO boundary, so the decode edges are hit repeatedly.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE,
        SLOT_CLEAN,
        SLOT_DIRTY,
        SLOT_WRITING
    } slot_state_e;

    typedef enum logic {
        WB_IDLE,
        WB_BUSY
    } wb_state_e;

endpackage

// File: rtl/dsw_mmio_dec.sv
module dsw_mmio_dec #(
    parameter int               ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] MMIO_BASE  = 'hC000_0000,
    parameter logic [ADDR_W-1:0] MMIO_LIMIT = 'hE000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_mmio
);

    // Half-open window: base included, limit excluded.
    always_comb begin
        is_mmio = (addr >= MMIO_BASE) && (addr < MMIO_LIMIT);
    end

endmodule

// File: rtl/dsw_slot.sv
module dsw_slot
    import dsw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill,
    input  logic              fill_dirty,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              release_req,
    input  logic              grant,
    input  logic              done,
    output logic              busy,
    output logic              dirty,
    output logic              wb_pending,
    output logic [ADDR_W-1:0] word_addr,
    output logic [DATA_W-1:0] word_data
);

    localparam int              OFS_W      = $clog2(DATA_W / 8);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << OFS_W) - ADDR_W'(1));

    slot_state_e       state_q, state_d;
    logic              rel_pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE:    if (fill)        state_d = fill_dirty ? SLOT_DIRTY : SLOT_CLEAN;
            SLOT_CLEAN:   if (release_req) state_d = SLOT_FREE;
            SLOT_DIRTY:   if (grant)       state_d = SLOT_WRITING;
            SLOT_WRITING: if (done)        state_d = (rel_pend_q || release_req) ? SLOT_FREE : SLOT_CLEAN;
            default:                       state_d = SLOT_FREE;
        endcase
    end

    // A release that arrives while repair is outstanding is held here
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_pend_q <= 1'b0;
        end else if (state_q == SLOT_WRITING && done) begin
            rel_pend_q <= 1'b0;
        end else if (release_req && (state_q == SLOT_DIRTY || state_q == SLOT_WRITING)) begin
            rel_pend_q <= 1'b1;
        end
    end

    // Payload: word-aligned address and corrected data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (state_q == SLOT_FREE && fill) begin
            addr_q <= fill_addr & ALIGN_MASK;
            data_q <= fill_data;
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != SLOT_FREE);
        dirty      = (state_q == SLOT_DIRTY) || (state_q == SLOT_WRITING);
        wb_pending = (state_q == SLOT_DIRTY);
        word_addr  = addr_q;
        word_data  = data_q;
    end

endmodule

// File: rtl/dsw_wb_engine.sv
module dsw_wb_engine
    import dsw_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int IDX_W   = 2,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BUF-1:0] pending,
    input  logic [ADDR_W-1:0]  slot_addr [NUM_BUF],
    input  logic [DATA_W-1:0]  slot_data [NUM_BUF],
    input  logic               wb_ack,
    output logic [NUM_BUF-1:0] grant,
    output logic [NUM_BUF-1:0] done,
    output logic               wb_valid,
    output logic [IDX_W-1:0]   wb_buf,
    output logic [ADDR_W-1:0]  wb_addr,
    output logic [DATA_W-1:0]  wb_data,
    output logic [CNT_W-1:0]   scrub_cnt
);

    wb_state_e        state_q, state_d;
    logic [IDX_W-1:0] cur_q;
    logic [IDX_W-1:0] pick;
    logic             any_pending;
    logic [CNT_W-1:0] cnt_q;

    // Fixed priority: lowest index wins
    always_comb begin
        pick        = '0;
        any_pending = 1'b0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (pending[i]) begin
                pick        = IDX_W'(i);
                any_pending = 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WB_IDLE;
            cur_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == WB_IDLE && any_pending) begin
                cur_q <= pick;
            end
            if (state_q == WB_BUSY && wb_ack) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WB_IDLE: if (any_pending) state_d = WB_BUSY;
            WB_BUSY: if (wb_ack)      state_d = WB_IDLE;
            default:                  state_d = WB_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        grant     = '0;
        done      = '0;
        wb_valid  = 1'b0;
        unique case (state_q)
            WB_IDLE: if (any_pending) grant = NUM_BUF'(1) << pick;
            WB_BUSY: begin
                wb_valid = 1'b1;
                if (wb_ack) done = NUM_BUF'(1) << cur_q;
            end
            default: ;
        endcase
        wb_buf    = cur_q;
        wb_addr   = slot_addr[cur_q];
        wb_data   = slot_data[cur_q];
        scrub_cnt = cnt_q;
    end

endmodule

// File: rtl/dsw_demand_scrub.sv
module dsw_demand_scrub
    import dsw_pkg::*;
#(
    parameter int                NUM_BUF    = 4,
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 64,
    parameter int                CNT_W      = 16,
    parameter logic [ADDR_W-1:0] MMIO_BASE  = 'hC000_0000,
    parameter logic [ADDR_W-1:0] MMIO_LIMIT = 'hE000_0000,
    localparam int               IDX_W      = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_valid,
    input  logic [IDX_W-1:0]   rd_buf,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0]  rd_data,
    input  logic               rd_ce,
    input  logic               rd_ue,
    output logic               req_valid,
    output logic [IDX_W-1:0]   req_buf,
    output logic [DATA_W-1:0]  req_data,
    output logic               req_ce,
    output logic               req_ue,
    output logic               wb_valid,
    output logic [IDX_W-1:0]   wb_buf,
    output logic [ADDR_W-1:0]  wb_addr,
    output logic [DATA_W-1:0]  wb_data,
    input  logic               wb_ack,
    input  logic               rel_valid,
    input  logic [IDX_W-1:0]   rel_buf,
    output logic [NUM_BUF-1:0] buf_busy,
    output logic [NUM_BUF-1:0] buf_dirty,
    output logic [CNT_W-1:0]   scrub_cnt
);

    logic               rd_is_mmio;
    logic               scrub_here;
    logic [NUM_BUF-1:0] pend_vec;
    logic [NUM_BUF-1:0] grant_vec;
    logic [NUM_BUF-1:0] done_vec;
    logic [ADDR_W-1:0]  slot_addr [NUM_BUF];
    logic [DATA_W-1:0]  slot_data [NUM_BUF];

    dsw_mmio_dec #(
        .ADDR_W     (ADDR_W),
        .MMIO_BASE  (MMIO_BASE),
        .MMIO_LIMIT (MMIO_LIMIT)
    ) u_dec (
        .addr    (rd_addr),
        .is_mmio (rd_is_mmio)
    );

    // Only a corrected DRAM read marks its buffer for repair
    always_comb begin
        scrub_here = rd_ce && !rd_ue && !rd_is_mmio;
    end

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
        dsw_slot #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .fill        (rd_valid && (rd_buf == IDX_W'(g))),
            .fill_dirty  (scrub_here),
            .fill_addr   (rd_addr),
            .fill_data   (rd_data),
            .release_req (rel_valid && (rel_buf == IDX_W'(g))),
            .grant       (grant_vec[g]),
            .done        (done_vec[g]),
            .busy        (buf_busy[g]),
            .dirty       (buf_dirty[g]),
            .wb_pending  (pend_vec[g]),
            .word_addr   (slot_addr[g]),
            .word_data   (slot_data[g])
        );
    end

    dsw_wb_engine #(
        .NUM_BUF (NUM_BUF),
        .IDX_W   (IDX_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W)
    ) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pend_vec),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .wb_ack    (wb_ack),
        .grant     (grant_vec),
        .done      (done_vec),
        .wb_valid  (wb_valid),
        .wb_buf    (wb_buf),
        .wb_addr   (wb_addr),
        .wb_data   (wb_data),
        .scrub_cnt (scrub_cnt)
    );

    // Requester return path: one register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_buf   <= '0;
            req_data  <= '0;
            req_ce    <= 1'b0;
            req_ue    <= 1'b0;
        end else begin
            req_valid <= rd_valid;
            if (rd_valid) begin
                req_buf  <= rd_buf;
                req_data <= rd_data;
                req_ce   <= rd_ce && !rd_ue;
                req_ue   <= rd_ue;
            end
        end
    end

endmodule

// File: rtl/dsw_demand_scrub_chk.sv
module dsw_demand_scrub_chk #(
    parameter int                NUM_BUF    = 4,
    parameter int                IDX_W      = 2,
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 64,
    parameter int                CNT_W      = 16,
    parameter logic [ADDR_W-1:0] MMIO_BASE  = 'hC000_0000,
    parameter logic [ADDR_W-1:0] MMIO_LIMIT = 'hE000_0000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_valid,
    input logic [IDX_W-1:0]   rd_buf,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic               rd_ce,
    input logic               rd_ue,
    input logic               req_valid,
    input logic [IDX_W-1:0]   req_buf,
    input logic               req_ue,
    input logic               wb_valid,
    input logic [IDX_W-1:0]   wb_buf,
    input logic [ADDR_W-1:0]  wb_addr,
    input logic [DATA_W-1:0]  wb_data,
    input logic               wb_ack,
    input logic [NUM_BUF-1:0] buf_busy,
    input logic [NUM_BUF-1:0] buf_dirty,
    input logic [CNT_W-1:0]   scrub_cnt
);

    logic in_window;
    always_comb begin
        in_window = (rd_addr >= MMIO_BASE) && (rd_addr < MMIO_LIMIT);
    end

    // Input assumptions (R9, R8)
    a_r9_fill_only_free: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !buf_busy[rd_buf]);
    a_r8_ack_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |-> wb_valid);

    a_r1_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> req_valid && req_buf == $past(rd_buf) && req_ue == $past(rd_ue));
    a_r1_req_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !req_valid);

    a_r2_ce_dram_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_ce && !rd_ue && !in_window |=> buf_dirty[$past(rd_buf)]);
    a_r3_no_ce_clean: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ce |=> buf_busy[$past(rd_buf)] && !buf_dirty[$past(rd_buf)]);
    a_r4_ue_clean: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_ue |=> !buf_dirty[$past(rd_buf)]);
    a_r5_mmio_clean: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && in_window |=> !buf_dirty[$past(rd_buf)]);

    a_r6_wb_targets_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> buf_dirty[wb_buf]);
    a_r7_wb_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_addr[2:0] == 3'b000);
    a_r8_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ack |=> wb_valid && $stable(wb_buf) && $stable(wb_addr) && $stable(wb_data));

    a_r9_free_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(buf_dirty) & ~buf_busy)) |-> $past(wb_valid && wb_ack));

    a_r10_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && wb_ack |=> scrub_cnt == $past(scrub_cnt) + CNT_W'(1));
    a_r10_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid && wb_ack) |=> $stable(scrub_cnt));

endmodule

bind dsw_demand_scrub dsw_demand_scrub_chk #(
    .NUM_BUF    (NUM_BUF),
    .IDX_W      (IDX_W),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W),
    .MMIO_BASE  (MMIO_BASE),
    .MMIO_LIMIT (MMIO_LIMIT)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_buf    (rd_buf),
    .rd_addr   (rd_addr),
    .rd_ce     (rd_ce),
    .rd_ue     (rd_ue),
    .req_valid (req_valid),
    .req_buf   (req_buf),
    .req_ue    (req_ue),
    .wb_valid  (wb_valid),
    .wb_buf    (wb_buf),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .wb_ack    (wb_ack),
    .buf_busy  (buf_busy),
    .buf_dirty (buf_dirty),
    .scrub_cnt (scrub_cnt)
);

// File: tb/test_dsw_demand_scrub.sv
module test_dsw_demand_scrub;

    localparam int NB = 4;
    localparam int IW = 2;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int CW = 16;
    localparam logic [AW-1:0] MB = 32'hC000_0000;
    localparam logic [AW-1:0] ML = 32'hE000_0000;
    localparam int S_FREE = 0, S_CLEAN = 1, S_DIRTY = 2, S_WRITING = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          rd_valid, rd_ce, rd_ue, wb_ack, rel_valid;
    logic [IW-1:0] rd_buf, rel_buf;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          req_valid, req_ce, req_ue, wb_valid;
    logic [IW-1:0] req_buf, wb_buf;
    logic [DW-1:0] req_data, wb_data;
    logic [AW-1:0] wb_addr;
    logic [NB-1:0] buf_busy, buf_dirty;
    logic [CW-1:0] scrub_cnt;

    dsw_demand_scrub #(
        .NUM_BUF (NB), .ADDR_W (AW), .DATA_W (DW), .CNT_W (CW),
        .MMIO_BASE (MB), .MMIO_LIMIT (ML)
    ) i_dsw_demand_scrub (
        .clk (clk), .rst_n (rst_n),
        .rd_valid (rd_valid), .rd_buf (rd_buf), .rd_addr (rd_addr), .rd_data (rd_data),
        .rd_ce (rd_ce), .rd_ue (rd_ue),
        .req_valid (req_valid), .req_buf (req_buf), .req_data (req_data),
        .req_ce (req_ce), .req_ue (req_ue),
        .wb_valid (wb_valid), .wb_buf (wb_buf), .wb_addr (wb_addr), .wb_data (wb_data),
        .wb_ack (wb_ack), .rel_valid (rel_valid), .rel_buf (rel_buf),
        .buf_busy (buf_busy), .buf_dirty (buf_dirty), .scrub_cnt (scrub_cnt)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // Reference model
    int            m_st   [NB];
    bit            m_pend [NB];
    logic [AW-1:0] m_addr [NB];
    logic [DW-1:0] m_data [NB];
    string         m_tag  [NB];
    bit            m_wbb, m_held;
    int            m_wbbuf;
    logic [CW-1:0] m_cnt;
    bit            m_rv, m_rce, m_rue;
    logic [IW-1:0] m_rbuf;
    logic [DW-1:0] m_rdata;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit in_mmio(logic [AW-1:0] a);
        return (a >= MB) && (a < ML);
    endfunction

    task automatic check_all();
        logic [NB-1:0] eb, ed;
        for (int i = 0; i < NB; i++) begin
            eb[i] = (m_st[i] != S_FREE);
            ed[i] = (m_st[i] == S_DIRTY) || (m_st[i] == S_WRITING);
            chk({m_st[i] == S_FREE ? "R9" : m_tag[i], " buf_dirty bit"}, 64'(buf_dirty[i]), 64'(ed[i]));
        end
        chk("R9 buf_busy", 64'(buf_busy), 64'(eb));
        chk("R6 wb_valid", 64'(wb_valid), 64'(m_wbb));
        if (m_wbb) begin
            chk("R6 wb_buf", 64'(wb_buf), 64'(m_wbbuf));
            chk(m_held ? "R8 wb_addr held" : "R7 wb_addr", 64'(wb_addr), 64'(m_addr[m_wbbuf] & ~32'h7));
            chk(m_held ? "R8 wb_data held" : "R7 wb_data", wb_data, m_data[m_wbbuf]);
        end
        chk("R10 scrub_cnt", 64'(scrub_cnt), 64'(m_cnt));
        chk("R1 req_valid", 64'(req_valid), 64'(m_rv));
        if (m_rv) begin
            chk("R1 req_buf", 64'(req_buf), 64'(m_rbuf));
            chk("R1 req_data", req_data, m_rdata);
            chk("R1 req_ce", 64'(req_ce), 64'(m_rce));
            chk("R1 req_ue", 64'(req_ue), 64'(m_rue));
        end
    endtask

    // Model update, applied at each active edge from the inputs driven before it
    task automatic step_model();
        int old [NB];
        bit acked;
        int lo;
        for (int i = 0; i < NB; i++) old[i] = m_st[i];
        acked  = m_wbb && wb_ack;
        m_held = m_wbb && !wb_ack;
        if (acked) begin
            m_st[m_wbbuf]   = (m_pend[m_wbbuf] || (rel_valid && rel_buf == IW'(m_wbbuf))) ? S_FREE : S_CLEAN;
            m_pend[m_wbbuf] = 1'b0;
            m_cnt           = m_cnt + 1'b1;
            m_wbb           = 1'b0;
        end else if (!m_wbb) begin
            lo = -1;
            for (int i = NB - 1; i >= 0; i--) if (old[i] == S_DIRTY) lo = i;
            if (lo >= 0) begin
                m_st[lo] = S_WRITING;
                m_wbb    = 1'b1;
                m_wbbuf  = lo;
            end
        end
        if (rel_valid) begin
            if (old[rel_buf] == S_CLEAN) m_st[rel_buf] = S_FREE;
            else if (old[rel_buf] == S_DIRTY || (old[rel_buf] == S_WRITING && !acked)) m_pend[rel_buf] = 1'b1;
        end
        if (rd_valid && old[rd_buf] == S_FREE) begin
            m_addr[rd_buf] = rd_addr;
            m_data[rd_buf] = rd_data;
            if (rd_ue)                m_tag[rd_buf] = "R4";
            else if (!rd_ce)          m_tag[rd_buf] = "R3";
            else if (in_mmio(rd_addr)) m_tag[rd_buf] = "R5";
            else                      m_tag[rd_buf] = "R2";
            m_st[rd_buf] = (m_tag[rd_buf] == "R2") ? S_DIRTY : S_CLEAN;
        end
        m_rv = rd_valid;
        if (rd_valid) begin
            m_rbuf  = rd_buf;
            m_rdata = rd_data;
            m_rce   = rd_ce && !rd_ue;
            m_rue   = rd_ue;
        end
    endtask

    task automatic drive_rd(int b, logic [AW-1:0] a, bit ce, bit ue);
        rd_valid = 1'b1;
        rd_buf   = IW'(b);
        rd_addr  = a;
        rd_data  = {$urandom, $urandom};
        rd_ce    = ce;
        rd_ue    = ue;
    endtask

    function automatic logic [AW-1:0] rand_addr();
        unique case ($urandom % 6)
            0: return MB;
            1: return ML - 1;
            2: return ML;
            3: return MB - 8;
            4: return MB + ($urandom % (ML - MB));
            default: return $urandom % MB;
        endcase
    endfunction

    task automatic pick_inputs(int cyc);
        int free_list [NB];
        int nfree;
        rd_valid = 1'b0; rel_valid = 1'b0; wb_ack = 1'b0;
        rd_ce = 1'b0; rd_ue = 1'b0;
        if (cyc < 20) begin
            unique case (cyc)
                0:  drive_rd(0, 32'h1000_0013, 1, 0);   // R2 dirty, unaligned address (R7)
                1:  drive_rd(1, MB, 1, 0);              // R5 lower window edge
                2:  drive_rd(2, 32'h2000_0008, 1, 1);   // R4 ue dominates
                3:  drive_rd(3, ML, 0, 0);              // R3 no ce, first DRAM word above window
                4:  begin rel_valid = 1'b1; rel_buf = 2'd0; end  // R9 release while writing
                5:  begin rel_valid = 1'b1; rel_buf = 2'd3; end  // R9 release clean
                6:  begin rel_valid = 1'b1; rel_buf = 2'd1; end
                8:  wb_ack = 1'b1;                      // R10 first completion
                9:  begin rel_valid = 1'b1; rel_buf = 2'd3; end  // R9 release of a free buffer
                10: drive_rd(3, 32'h0000_0100, 1, 0);
                11: drive_rd(1, MB - 8, 1, 0);          // R2 just below the window
                12: drive_rd(0, 32'h0040_0000, 1, 0);  // R6 lower index queued behind
                13: begin rel_valid = 1'b1; rel_buf = 2'd2; end
                14: wb_ack = 1'b1;
                16: drive_rd(2, ML - 1, 1, 0);          // R5 upper window edge
                default: ;
            endcase
        end else begin
            nfree = 0;
            for (int i = 0; i < NB; i++) if (m_st[i] == S_FREE) begin free_list[nfree] = i; nfree++; end
            if (nfree > 0 && ($urandom % 2 == 0))
                drive_rd(free_list[$urandom % nfree], rand_addr(), ($urandom % 2) == 0, ($urandom % 8) == 0);
            if ($urandom % 3 == 0) begin
                rel_valid = 1'b1;
                rel_buf   = IW'($urandom % NB);
            end
            wb_ack = m_wbb && ($urandom % 3 == 0);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NB; i++) begin
            m_st[i] = S_FREE; m_pend[i] = 1'b0; m_addr[i] = '0; m_data[i] = '0; m_tag[i] = "R9";
        end
        m_wbb = 1'b0; m_held = 1'b0; m_wbbuf = 0; m_cnt = '0;
        m_rv = 1'b0; m_rce = 1'b0; m_rue = 1'b0; m_rbuf = '0; m_rdata = '0;
        rst_n = 1'b0;
        rd_valid = 1'b0; rd_buf = '0; rd_addr = '0; rd_data = '0; rd_ce = 1'b0; rd_ue = 1'b0;
        wb_ack = 1'b0; rel_valid = 1'b0; rel_buf = '0;
        repeat (3) begin
            @(negedge clk);
            chk("R11 reset buf_busy", 64'(buf_busy), 64'd0);
            chk("R11 reset buf_dirty", 64'(buf_dirty), 64'd0);
            chk("R11 reset wb_valid", 64'(wb_valid), 64'd0);
            chk("R11 reset req_valid", 64'(req_valid), 64'd0);
            chk("R11 reset scrub_cnt", 64'(scrub_cnt), 64'd0);
        end
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            pick_inputs(cyc);
            @(posedge clk);
            step_model();
            @(negedge clk);
            check_all();
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule